// File: doc/BRIEF.md
# Overcurrent Fault Integrator Timer

This block keeps the overcurrent history of one powered output port. It integrates overcurrent time in an up/down counter. The counter rises by one on every clock cycle in which the current comparator reports a level above the fault threshold. It falls by one only once per 16, 32, 64 or 128 cycles while the current stays below it. Because the fall is slower than the rise, a train of short overcurrent bursts adds up and trips the port just as a long one does. When the counter reaches the programmed fault limit, the block asks for the port to be switched off and latches an overcurrent flag.

With restart enabled, a trip leaves the counter full. The counter then keeps falling at the slow rate, and the port may not be switched on again until it reaches zero. The ratio of the rise rate to the fall rate therefore bounds the on-time duty cycle of the pass transistor. With restart disabled, a trip clears the counter. The same block times the startup phase. If current limiting is still active when the startup window ends, the block asks for a power-off and latches a start-fault flag. A port clear command empties the counter and drops both flags at once.

The state machine has four states:
- `ST_IDLE`: the port is unpowered.
- `ST_START`: the startup window is running.
- `ST_ON`: the port is powered and the counter integrates overcurrent.
- `ST_COOL`: a restart-enabled cool-down after a trip.

Its transitions are:
- Idle to Start: `port_on` rises while `may_power` is high.
- Start to On: the window expires without current limiting.
- Start to Idle: `port_on` falls, or the window expires with limiting active (start fault).
- On to Cool: trip with restart enabled.
- On to Idle: trip with restart disabled, or `port_on` falls.
- Cool to Idle: the counter reaches zero.
- Any state to Idle: `port_clear`.

Top module: `port_fault_integrator`

## Requirements
- R1: After reset `pwr_off_req`, `oc_fault` and `start_fault` are 0 and `may_power` is 1.
- R2: In the powered state a continuous overcurrent (`over_flt` = 1) sets `oc_fault` and a one-cycle `pwr_off_req` exactly `fault_limit` clock cycles after it starts, counted from a counter at zero.
- R3: The counter rises by one per overcurrent cycle and falls by one per 2^(4+`duty_sel`) cycles without overcurrent: `duty_sel` 0, 1, 2, 3 gives 16, 32, 64, 128. So a pattern of 1 overcurrent cycle and 15 quiet cycles accumulates and trips, while 1 and 16 does not.
- R4: A partially filled counter keeps its value. After 6 overcurrent cycles and 32 quiet cycles with `duty_sel` = 0, the counter holds 4, and a new continuous overcurrent trips after `fault_limit` - 4 cycles.
- R5: With `restart_en` = 1 a trip leaves the counter at `fault_limit`. `may_power` stays 0 for `fault_limit` x 2^(4+`duty_sel`) cycles after the trip and returns to 1 in the next cycle.
- R6: With `restart_en` = 0 a trip clears the counter, so `may_power` is 1 in the same cycle that `oc_fault` first reads 1.
- R7: The startup window begins when `port_on` rises. If `in_limit` is 1 when it expires, `start_limit` cycles after entry (visible `start_limit` + 1 cycles after `port_on` is driven), `start_fault` and a one-cycle `pwr_off_req` are set. If `in_limit` is 0, the port enters the powered state with no flag.
- R8: A rise of `port_on` while `may_power` is 0 is ignored: no startup window runs and no start fault can appear.
- R9: `port_clear` empties the counter and drops `oc_fault`, `start_fault` and `pwr_off_req` in the next cycle, and `may_power` is 1 from then on.
- R10: `oc_fault` and `start_fault` stay set until `port_clear`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_clear | input | 1 | Port reset / shutdown command: clears counter and flags |
| port_on | input | 1 | Port supply requested by the controller; its rise starts the startup window |
| over_flt | input | 1 | Sensed current above the fault threshold |
| in_limit | input | 1 | Current limiting active |
| restart_en | input | 1 | Keep the counter and enforce cool-down after a trip |
| duty_sel | input | 2 | Slow fall rate: one step per 2^(4+duty_sel) cycles |
| fault_limit | input | CNT_W | Counter value that trips the port |
| start_limit | input | START_W | Startup window length in cycles |
| pwr_off_req | output | 1 | One-cycle request to switch the port off |
| oc_fault | output | 1 | Sticky overcurrent fault flag |
| start_fault | output | 1 | Sticky start fault flag |
| may_power | output | 1 | Port may be switched on (idle and counter empty) |

## Verification
The internal counter cannot be observed at the ports, so its value is measured indirectly: it is inferred from the number of overcurrent cycles still needed to trip, or from the length of the cool-down. The hardest case is a counter that sits partly full while the prescaler is in the middle of a fall step. The stimulus reaches it with exact burst patterns: 1 high and 15 or 16 low cycles, and 6 high followed by two full fall periods. The following trip time then exposes any off-by-one in either rate. Cool-down lengths are measured for several `duty_sel` and limit pairs, and a `port_on` rise is injected in the middle of a cool-down.

// File: rtl/pfi_pkg.sv
package pfi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_ON    = 2'd2,
        ST_COOL  = 2'd3
    } pfi_state_e;

    localparam int SEL_W          = 2;
    localparam int DECAY_BASE_LOG = 4;
endpackage

// File: rtl/pfi_decay_tick.sv
module pfi_decay_tick #(
    parameter int BASE_LOG2 = 4,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = BASE_LOG2 + (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] last;

    always_comb begin
        last = PRE_W'((32'd1 << (BASE_LOG2 + int'(sel))) - 32'd1);
        tick = run && (pre >= last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre <= '0;
        else if (!run || tick)
            pre <= '0;
        else
            pre <= pre + 1'b1;
    end

    // Fall steps are at least 16 cycles apart
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/pfi_start_timer.sv
module pfi_start_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] st;

    always_comb
        expire = run && (({1'b0, st} + (W+1)'(1)) >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= '0;
        else if (!run)
            st <= '0;
        else if (st != '1)
            st <= st + 1'b1;
    end

    // Each window starts from zero
    assert_fresh_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (st == '0));
endmodule

// File: rtl/pfi_fault_counter.sv
module pfi_fault_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    input  logic         dec,
    input  logic [W-1:0] limit,
    output logic         zero,
    output logic         reach,
    output logic         last_step
);
    logic [W-1:0] cnt;

    always_comb begin
        zero      = (cnt == '0);
        reach     = inc && (({1'b0, cnt} + (W+1)'(1)) >= {1'b0, limit});
        last_step = dec && (cnt == W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (inc)
            cnt <= reach ? limit : cnt + 1'b1;
        else if (dec && !zero)
            cnt <= cnt - 1'b1;
    end

    // Without up-count or clear the counter holds or falls by exactly one
    assert_slow_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !inc) |=> (cnt == $past(cnt) || cnt == W'($past(cnt) - 1'b1)));
endmodule

// File: rtl/port_fault_integrator.sv
module port_fault_integrator
    import pfi_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int START_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               port_clear,
    input  logic               port_on,
    input  logic               over_flt,
    input  logic               in_limit,
    input  logic               restart_en,
    input  logic [SEL_W-1:0]   duty_sel,
    input  logic [CNT_W-1:0]   fault_limit,
    input  logic [START_W-1:0] start_limit,
    output logic               pwr_off_req,
    output logic               oc_fault,
    output logic               start_fault,
    output logic               may_power
);
    pfi_state_e state, state_nx;
    logic port_on_q, on_rise;
    logic inc, dec_run, dec_tick;
    logic cnt_zero, reach, last_step, cnt_clear;
    logic st_run, expire, start_trip, trip;

    always_comb begin
        on_rise    = port_on && !port_on_q;
        inc        = (state == ST_ON) && over_flt && !port_clear;
        trip       = reach;
        cnt_clear  = port_clear || (trip && !restart_en);
        dec_run    = !inc && !cnt_zero && (state != ST_START) && !port_clear;
        st_run     = (state == ST_START) && !port_clear;
        start_trip = expire && port_on && in_limit;
        may_power  = (state == ST_IDLE) && cnt_zero;
    end

    pfi_decay_tick #(.BASE_LOG2(DECAY_BASE_LOG), .SEL_W(SEL_W)) u_decay (
        .clk(clk), .rst_n(rst_n), .run(dec_run), .sel(duty_sel), .tick(dec_tick)
    );

    pfi_fault_counter #(.W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .inc(inc), .dec(dec_tick),
        .limit(fault_limit), .zero(cnt_zero), .reach(reach), .last_step(last_step)
    );

    pfi_start_timer #(.W(START_W)) u_start (
        .clk(clk), .rst_n(rst_n), .run(st_run), .limit(start_limit), .expire(expire)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (on_rise && cnt_zero) state_nx = ST_START;
            ST_START: begin
                if (!port_on)        state_nx = ST_IDLE;
                else if (start_trip) state_nx = ST_IDLE;
                else if (expire)     state_nx = ST_ON;
            end
            ST_ON: begin
                if (trip)          state_nx = restart_en ? ST_COOL : ST_IDLE;
                else if (!port_on) state_nx = ST_IDLE;
            end
            ST_COOL:  if (last_step || cnt_zero) state_nx = ST_IDLE;
        endcase
        if (port_clear) state_nx = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            port_on_q <= 1'b0;
        end else begin
            state     <= state_nx;
            port_on_q <= port_on;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_off_req <= 1'b0;
            oc_fault    <= 1'b0;
            start_fault <= 1'b0;
        end else if (port_clear) begin
            pwr_off_req <= 1'b0;
            oc_fault    <= 1'b0;
            start_fault <= 1'b0;
        end else begin
            pwr_off_req <= trip || start_trip;
            oc_fault    <= oc_fault || trip;
            start_fault <= start_fault || start_trip;
        end
    end

    assert_off_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off_req |=> !pwr_off_req);
    assert_trip_requests_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oc_fault) |-> pwr_off_req);
    assert_start_needs_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && $past(state) == ST_IDLE) |-> $past(cnt_zero));
    assert_start_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_fault) |-> $past(in_limit));
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_fault && !port_clear) |=> oc_fault);
    assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        port_clear |=> (!oc_fault && !start_fault && !pwr_off_req));
endmodule

// File: tb/port_fault_integrator_tb.sv
`timescale 1ns/1ps
module port_fault_integrator_tb;
    localparam int CNT_W = 12;
    localparam int START_W = 10;
    localparam int START_LEN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic port_clear = 1'b0, port_on = 1'b0, over_flt = 1'b0, in_limit = 1'b0;
    logic restart_en = 1'b0;
    logic [1:0] duty_sel = 2'd0;
    logic [CNT_W-1:0] fault_limit = CNT_W'(10);
    logic [START_W-1:0] start_limit = START_W'(START_LEN);
    logic pwr_off_req, oc_fault, start_fault, may_power;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    port_fault_integrator #(.CNT_W(CNT_W), .START_W(START_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .port_clear(port_clear), .port_on(port_on),
        .over_flt(over_flt), .in_limit(in_limit), .restart_en(restart_en),
        .duty_sel(duty_sel), .fault_limit(fault_limit), .start_limit(start_limit),
        .pwr_off_req(pwr_off_req), .oc_fault(oc_fault), .start_fault(start_fault),
        .may_power(may_power)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_clear();
        port_clear = 1'b1;
        @(negedge clk);
        port_clear = 1'b0;
        port_on = 1'b0; over_flt = 1'b0; in_limit = 1'b0;
        @(negedge clk);
    endtask

    // Enter the powered state through a clean startup window
    task automatic bring_up(input string tag);
        chk({tag, " may_power before start"}, int'(may_power), 1);
        in_limit = 1'b0;
        port_on = 1'b1;
        repeat (START_LEN + 1) @(negedge clk);
        chk({tag, " R7 no start fault"}, int'(start_fault), 0);
    endtask

    task automatic t_reset();
        chk("R1 pwr_off_req", int'(pwr_off_req), 0);
        chk("R1 oc_fault", int'(oc_fault), 0);
        chk("R1 start_fault", int'(start_fault), 0);
        chk("R1 may_power", int'(may_power), 1);
    endtask

    task automatic t_continuous_no_restart();
        restart_en = 1'b0; duty_sel = 2'd0; fault_limit = CNT_W'(10);
        bring_up("R2");
        over_flt = 1'b1;
        repeat (9) @(negedge clk);
        chk("R2 no trip before limit", int'(oc_fault), 0);
        @(negedge clk);
        chk("R2 trip at limit", int'(oc_fault), 1);
        chk("R2 off request", int'(pwr_off_req), 1);
        chk("R6 may_power at trip", int'(may_power), 1);
        over_flt = 1'b0; port_on = 1'b0;
        @(negedge clk);
        chk("R2 off request one cycle", int'(pwr_off_req), 0);
        repeat (20) @(negedge clk);
        chk("R10 overcurrent flag sticky", int'(oc_fault), 1);
        port_clear = 1'b1;
        @(negedge clk);
        port_clear = 1'b0;
        chk("R9 clear drops flag", int'(oc_fault), 0);
        @(negedge clk);
    endtask

    task automatic t_startup_fault();
        in_limit = 1'b1; port_on = 1'b1;
        repeat (START_LEN) @(negedge clk);
        chk("R7 no start fault before expiry", int'(start_fault), 0);
        @(negedge clk);
        chk("R7 start fault at expiry", int'(start_fault), 1);
        chk("R7 off request", int'(pwr_off_req), 1);
        port_on = 1'b0; in_limit = 1'b0;
        repeat (10) @(negedge clk);
        chk("R10 start flag sticky", int'(start_fault), 1);
        do_clear();
        chk("R9 clear drops start flag", int'(start_fault), 0);
    endtask

    task automatic t_partial_decay();
        restart_en = 1'b0; duty_sel = 2'd0; fault_limit = CNT_W'(10);
        bring_up("R4");
        over_flt = 1'b1;
        repeat (6) @(negedge clk);
        over_flt = 1'b0;
        repeat (32) @(negedge clk);
        over_flt = 1'b1;
        repeat (5) @(negedge clk);
        chk("R4 no trip after 5", int'(oc_fault), 0);
        @(negedge clk);
        chk("R4 trip after limit minus 4", int'(oc_fault), 1);
        do_clear();
    endtask

    task automatic t_short_bursts();
        restart_en = 1'b0; duty_sel = 2'd0; fault_limit = CNT_W'(4);
        bring_up("R3a");
        for (int p = 0; p < 10; p++) begin
            over_flt = 1'b1;
            @(negedge clk);
            over_flt = 1'b0;
            repeat (16) @(negedge clk);
        end
        chk("R3 1-on 16-off never trips", int'(oc_fault), 0);
        for (int p = 0; p < 3; p++) begin
            over_flt = 1'b1;
            @(negedge clk);
            over_flt = 1'b0;
            repeat (15) @(negedge clk);
        end
        chk("R3 no trip after 3 bursts", int'(oc_fault), 0);
        over_flt = 1'b1;
        @(negedge clk);
        over_flt = 1'b0;
        chk("R3 1-on 15-off trips on 4th burst", int'(oc_fault), 1);
        do_clear();
    endtask

    task automatic t_cool(input logic [1:0] sel, input int lim);
        int wait_len;
        restart_en = 1'b1; duty_sel = sel; fault_limit = CNT_W'(lim);
        bring_up("R5");
        over_flt = 1'b1;
        repeat (lim) @(negedge clk);
        chk("R5 trip", int'(oc_fault), 1);
        chk("R5 may_power low at trip", int'(may_power), 0);
        over_flt = 1'b0; port_on = 1'b0;
        wait_len = lim * (16 << sel);
        repeat (wait_len - 1) @(negedge clk);
        chk("R5 still cooling one cycle before end", int'(may_power), 0);
        @(negedge clk);
        chk("R5 may_power after cool-down", int'(may_power), 1);
        do_clear();
    endtask

    task automatic t_ignore_start();
        restart_en = 1'b1; duty_sel = 2'd0; fault_limit = CNT_W'(4);
        bring_up("R8");
        over_flt = 1'b1;
        repeat (4) @(negedge clk);
        over_flt = 1'b0; port_on = 1'b0;
        @(negedge clk);
        port_on = 1'b1; in_limit = 1'b1;
        repeat (START_LEN + 6) @(negedge clk);
        chk("R8 ignored start gives no start fault", int'(start_fault), 0);
        chk("R8 ignored start gives no off request", int'(pwr_off_req), 0);
        chk("R8 still blocked", int'(may_power), 0);
        port_on = 1'b0; in_limit = 1'b0;
        @(negedge clk);
        port_clear = 1'b1;
        @(negedge clk);
        port_clear = 1'b0;
        chk("R9 clear ends cool-down", int'(may_power), 1);
        chk("R9 clear drops overcurrent flag", int'(oc_fault), 0);
        @(negedge clk);
        // Counter must be empty: a full limit of overcurrent is needed again
        restart_en = 1'b0;
        bring_up("R9");
        over_flt = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 counter empty after clear", int'(oc_fault), 0);
        @(negedge clk);
        chk("R9 trip after full limit", int'(oc_fault), 1);
        do_clear();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_continuous_no_restart();
        t_startup_fault();
        t_partial_decay();
        t_short_bursts();
        t_cool(2'd0, 4);
        t_cool(2'd1, 8);
        t_cool(2'd2, 3);
        t_cool(2'd3, 2);
        t_ignore_start();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule